// File: doc/BRIEF.md
# Linear Array Readout Sequencer

This block is the digital timing core of a line image sensor. It receives the sensor's line clock and line reset as ordinary level inputs, sampled by a faster system clock. Every action is stepped on a detected falling edge of the line clock, called a tick below. From the rising and falling ticks of the line reset, it derives the charge integration window. It also drives a 0-based pixel channel index with a valid flag, a one-cycle trigger for each pixel sample, and an active-low end-of-scan pulse.

Several sensors can share the line clock and line reset and be read out one after another. The first sensor runs as a master and starts its readout from its own lead-in count after the reset falls. Each following sensor runs as a slave: after the reset falls it waits for its start input, which is driven by the previous sensor's end-of-scan. A reset rise that lands inside the readout is recorded in a sticky error flag, and the scan still runs to completion.

Top module: `lrs_sequencer`

## Requirements
- R1: After the synchronous system reset, `integ` is 0, `pix_valid` is 0, `pix_idx` is 0, `trig` is 0, `eos_n` is 1 and `err` is 0.
- R2: `integ` goes high on the 8th tick after the tick at which `line_rst` is first seen high. Tick 0 is the tick that sees the rise.
- R3: `integ` goes low on the 8th tick after the tick at which `line_rst` is first seen low.
- R4: In master mode (`slave_mode`=0), the tick that first sees `line_rst` low is clock 1. `pix_valid` rises with `pix_idx`=0 at clock 17 and stays so through clock 20.
- R5: Each pixel holds `pix_idx` for exactly 4 ticks. The index then steps by one, up to NPIX-1, so pixel i occupies clocks 17+4i to 20+4i.
- R6: `trig` is a single system-clock pulse on the third tick of each pixel slot (clock 19 for pixel 0). There is exactly one pulse per pixel, NPIX pulses per scan.
- R7: `eos_n` is 0 for exactly the 4 ticks that follow the last pixel slot. After that the block is idle, with `pix_valid`=0 and `eos_n`=1.
- R8: In slave mode (`slave_mode`=1), the block produces no pixels after the reset fall until a tick samples `ext_start_n`=0. The slot of pixel 0 starts at that tick.
- R9: A `line_rst` rise seen during a pixel slot or the end-of-scan slot sets `err`. `err` stays set until the system reset, and the scan still delivers all NPIX pixels and its end-of-scan.
- R10: `pix_idx` reads 0 whenever `pix_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the line inputs |
| rst | input | 1 | Synchronous active-high reset |
| line_clk | input | 1 | Sensor line clock; its falling edges are the ticks |
| line_rst | input | 1 | Sensor line reset; its high time sets the integration time |
| slave_mode | input | 1 | 0 = master start, 1 = wait for ext_start_n |
| ext_start_n | input | 1 | Active-low start from the preceding sensor's end-of-scan |
| integ | output | 1 | Integration window active |
| pix_valid | output | 1 | A pixel slot is in progress |
| pix_idx | output | $clog2(NPIX) | 0-based channel index of the current slot |
| trig | output | 1 | One-cycle sample trigger per pixel |
| eos_n | output | 1 | Active-low end-of-scan, one slot long |
| err | output | 1 | Sticky flag: reset rose during readout |

## Verification
A miscounted lead-in or slot counter moves the pixel 0 slot away from clock 17. Because the bench compares the index at fixed clock numbers against a table, such an error shows within one tick of the expected edge. A slip in the slot length accumulates over 64 pixels and shows as a wrong index or a missing end-of-scan near clock 273, while a mis-phased trigger shows in the clock number recorded for the first pulse. A lost error flag, or a scan aborted by the rogue reset rise, shows as a clear `err` or a trigger count short of NPIX.

// File: rtl/lrs_pkg.sv
package lrs_pkg;

    localparam int LEAD_CLKS   = 16;
    localparam int SLOT_CLKS   = 4;
    localparam int TRIG_PHASE  = 2;
    localparam int INTEG_DELAY = 8;

    typedef enum logic [2:0] {
        RD_IDLE,
        RD_LEAD,
        RD_WAIT,
        RD_SLOT,
        RD_EOS
    } rd_state_e;

    typedef struct packed {
        logic tick;
        logic rst_rise;
        logic rst_fall;
    } line_evt_t;

    function automatic logic in_readout(input rd_state_e s);
        return (s == RD_SLOT) || (s == RD_EOS);
    endfunction

endpackage

// File: rtl/lrs_edge_detect.sv
module lrs_edge_detect
    import lrs_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      line_clk,
    input  logic      line_rst,
    output line_evt_t evt
);
    logic lc_q;
    logic lr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lc_q <= 1'b0;
            lr_q <= 1'b0;
        end else begin
            lc_q <= line_clk;
            if (evt.tick) lr_q <= line_rst;
        end
    end

    always_comb begin
        evt.tick     = lc_q & ~line_clk;
        evt.rst_rise = evt.tick & line_rst & ~lr_q;
        evt.rst_fall = evt.tick & ~line_rst & lr_q;
    end
endmodule

// File: rtl/lrs_integ_window.sv
module lrs_integ_window
    import lrs_pkg::*;
#(
    parameter int DELAY = INTEG_DELAY
) (
    input  logic      clk,
    input  logic      rst,
    input  line_evt_t evt,
    output logic      integ
);
    localparam int CW = $clog2(DELAY + 1);

    logic [CW-1:0] open_cnt, close_cnt;
    logic          open_busy, close_busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            open_cnt   <= '0;
            close_cnt  <= '0;
            open_busy  <= 1'b0;
            close_busy <= 1'b0;
            integ      <= 1'b0;
        end else if (evt.tick) begin
            if (evt.rst_rise) begin
                open_busy <= 1'b1;
                open_cnt  <= '0;
            end else if (open_busy) begin
                if (open_cnt == CW'(DELAY - 1)) begin
                    open_busy <= 1'b0;
                    integ     <= 1'b1;
                end else begin
                    open_cnt <= open_cnt + 1'b1;
                end
            end

            if (evt.rst_fall) begin
                close_busy <= 1'b1;
                close_cnt  <= '0;
            end else if (close_busy) begin
                if (close_cnt == CW'(DELAY - 1)) begin
                    close_busy <= 1'b0;
                    integ      <= 1'b0;
                end else begin
                    close_cnt <= close_cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/lrs_readout.sv
module lrs_readout
    import lrs_pkg::*;
#(
    parameter int NPIX = 64,
    localparam int IDXW = $clog2(NPIX)
) (
    input  logic            clk,
    input  logic            rst,
    input  line_evt_t       evt,
    input  logic            slave_mode,
    input  logic            ext_start_n,
    output logic            pix_valid,
    output logic [IDXW-1:0] pix_idx,
    output logic            trig,
    output logic            eos_n,
    output logic            err
);
    localparam int LW = $clog2(LEAD_CLKS + 1);
    localparam int SW = $clog2(SLOT_CLKS);

    rd_state_e       state;
    logic [LW-1:0]   lead_cnt;
    logic [SW-1:0]   sub;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= RD_IDLE;
            lead_cnt  <= '0;
            sub       <= '0;
            pix_valid <= 1'b0;
            pix_idx   <= '0;
            trig      <= 1'b0;
            eos_n     <= 1'b1;
            err       <= 1'b0;
        end else begin
            trig <= 1'b0;
            if (evt.rst_rise && in_readout(state)) err <= 1'b1;
            if (evt.tick) begin
                unique case (state)
                    RD_IDLE: begin
                        if (evt.rst_fall) begin
                            if (slave_mode) begin
                                state <= RD_WAIT;
                            end else begin
                                state    <= RD_LEAD;
                                lead_cnt <= LW'(1);
                            end
                        end
                    end
                    RD_LEAD: begin
                        if (lead_cnt == LW'(LEAD_CLKS)) begin
                            state     <= RD_SLOT;
                            sub       <= '0;
                            pix_idx   <= '0;
                            pix_valid <= 1'b1;
                        end else begin
                            lead_cnt <= lead_cnt + 1'b1;
                        end
                    end
                    RD_WAIT: begin
                        if (!ext_start_n) begin
                            state     <= RD_SLOT;
                            sub       <= '0;
                            pix_idx   <= '0;
                            pix_valid <= 1'b1;
                        end
                    end
                    RD_SLOT: begin
                        if (sub == SW'(SLOT_CLKS - 1)) begin
                            sub <= '0;
                            if (pix_idx == IDXW'(NPIX - 1)) begin
                                state     <= RD_EOS;
                                pix_valid <= 1'b0;
                                pix_idx   <= '0;
                                eos_n     <= 1'b0;
                            end else begin
                                pix_idx <= pix_idx + 1'b1;
                            end
                        end else begin
                            sub <= sub + 1'b1;
                            if (sub == SW'(TRIG_PHASE - 1)) trig <= 1'b1;
                        end
                    end
                    RD_EOS: begin
                        if (sub == SW'(SLOT_CLKS - 1)) begin
                            state <= RD_IDLE;
                            sub   <= '0;
                            eos_n <= 1'b1;
                        end else begin
                            sub <= sub + 1'b1;
                        end
                    end
                    default: state <= RD_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/lrs_sequencer.sv
module lrs_sequencer
    import lrs_pkg::*;
#(
    parameter int NPIX = 64,
    localparam int IDXW = $clog2(NPIX)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            line_clk,
    input  logic            line_rst,
    input  logic            slave_mode,
    input  logic            ext_start_n,
    output logic            integ,
    output logic            pix_valid,
    output logic [IDXW-1:0] pix_idx,
    output logic            trig,
    output logic            eos_n,
    output logic            err
);
    line_evt_t evt;

    lrs_edge_detect u_edge (
        .clk      (clk),
        .rst      (rst),
        .line_clk (line_clk),
        .line_rst (line_rst),
        .evt      (evt)
    );

    lrs_integ_window #(.DELAY(INTEG_DELAY)) u_integ (
        .clk   (clk),
        .rst   (rst),
        .evt   (evt),
        .integ (integ)
    );

    lrs_readout #(.NPIX(NPIX)) u_rd (
        .clk         (clk),
        .rst         (rst),
        .evt         (evt),
        .slave_mode  (slave_mode),
        .ext_start_n (ext_start_n),
        .pix_valid   (pix_valid),
        .pix_idx     (pix_idx),
        .trig        (trig),
        .eos_n       (eos_n),
        .err         (err)
    );
endmodule

// File: rtl/lrs_sequencer_chk.sv
module lrs_sequencer_chk #(
    parameter int NPIX = 64,
    localparam int IDXW = $clog2(NPIX)
) (
    input logic            clk,
    input logic            rst,
    input logic            pix_valid,
    input logic [IDXW-1:0] pix_idx,
    input logic            trig,
    input logic            eos_n,
    input logic            err
);
    assert_idx_idle_R10: assert property (@(posedge clk) disable iff (rst)
        !pix_valid |-> pix_idx == '0);

    assert_eos_no_pixel_R7: assert property (@(posedge clk) disable iff (rst)
        !eos_n |-> !pix_valid);

    assert_trig_in_slot_R6: assert property (@(posedge clk) disable iff (rst)
        trig |-> pix_valid);

    assert_trig_single_R6: assert property (@(posedge clk) disable iff (rst)
        trig |=> !trig);

    assert_err_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        err |=> err);

    assert_idx_step_R5: assert property (@(posedge clk) disable iff (rst)
        (pix_valid && $past(pix_valid) && pix_idx != $past(pix_idx))
            |-> pix_idx == IDXW'($past(pix_idx) + 1'b1));
endmodule

bind lrs_sequencer lrs_sequencer_chk #(.NPIX(NPIX)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .pix_valid (pix_valid),
    .pix_idx   (pix_idx),
    .trig      (trig),
    .eos_n     (eos_n),
    .err       (err)
);

// File: tb/lrs_sequencer_tb.sv
module lrs_sequencer_tb;
    localparam int NPIX = 64;
    localparam int IDXW = $clog2(NPIX);
    localparam int LAST = 17 + 4 * NPIX + 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic line_clk = 1'b0;
    logic line_rst = 1'b0;
    logic slave_mode = 1'b0;
    logic ext_start_n = 1'b1;
    logic integ, pix_valid, trig, eos_n, err;
    logic [IDXW-1:0] pix_idx;

    int checks = 0;
    int errors = 0;
    int clock_no = 0;
    int trig_cnt = 0;
    int first_trig = -1;
    int eos_cycles = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    lrs_sequencer #(.NPIX(NPIX)) u_dut (
        .clk(clk), .rst(rst), .line_clk(line_clk), .line_rst(line_rst),
        .slave_mode(slave_mode), .ext_start_n(ext_start_n),
        .integ(integ), .pix_valid(pix_valid), .pix_idx(pix_idx),
        .trig(trig), .eos_n(eos_n), .err(err)
    );

    // vector: {clock number, valid, index, eos_n}
    localparam logic [25:0] VEC [0:11] = '{
        {16'd1,   1'b0, 8'd0,  1'b1},
        {16'd16,  1'b0, 8'd0,  1'b1},
        {16'd17,  1'b1, 8'd0,  1'b1},
        {16'd20,  1'b1, 8'd0,  1'b1},
        {16'd21,  1'b1, 8'd1,  1'b1},
        {16'd24,  1'b1, 8'd1,  1'b1},
        {16'd25,  1'b1, 8'd2,  1'b1},
        {16'd269, 1'b1, 8'd63, 1'b1},
        {16'd272, 1'b1, 8'd63, 1'b1},
        {16'd273, 1'b0, 8'd0,  1'b0},
        {16'd276, 1'b0, 8'd0,  1'b0},
        {16'd277, 1'b0, 8'd0,  1'b1}
    };

    always @(negedge clk) begin
        if (trig) begin
            trig_cnt++;
            if (first_trig < 0) first_trig = clock_no;
        end
        if (!eos_n) eos_cycles++;
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d (clock %0d)", req, act, exp, clock_no);
        end
    endtask

    task automatic tick(input logic lvl);
        @(negedge clk) line_clk = 1'b1;
        repeat (3) @(negedge clk);
        line_clk = 1'b0;
        line_rst = lvl;
        clock_no++;
        repeat (3) @(negedge clk);
    endtask

    task automatic sys_reset();
        rst = 1'b1;
        line_rst = 1'b0;
        line_clk = 1'b0;
        ext_start_n = 1'b1;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic clear_counts();
        trig_cnt = 0;
        first_trig = -1;
        eos_cycles = 0;
    endtask

    initial begin
        #900000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        sys_reset();
        // R1 reset state
        check("R1 integ", integ, 0);
        check("R1 pix_valid", pix_valid, 0);
        check("R1 pix_idx", pix_idx, 0);
        check("R1 trig", trig, 0);
        check("R1 eos_n", eos_n, 1);
        check("R1 err", err, 0);

        // R2 integration opens 8 ticks after the rise tick
        tick(1'b1);
        for (int k = 1; k <= 7; k++) tick(1'b1);
        check("R2 integ before 8th tick", integ, 0);
        tick(1'b1);
        check("R2 integ at 8th tick", integ, 1);
        repeat (4) tick(1'b1);

        // master scan walked from the vector table (R4, R5, R7), R3 along the way
        clear_counts();
        clock_no = 0;
        for (int c = 1; c <= LAST; c++) begin
            tick(1'b0);
            if (c == 8) check("R3 integ still open", integ, 1);
            if (c == 9) check("R3 integ closed", integ, 0);
            for (int v = 0; v < 12; v++) begin
                if (int'(VEC[v][25:10]) == c) begin
                    check("R4/R5 pix_valid", pix_valid, int'(VEC[v][9]));
                    check("R5 pix_idx", pix_idx, int'(VEC[v][8:1]));
                    check("R7 eos_n", eos_n, int'(VEC[v][0]));
                end
            end
        end
        check("R6 trigger count", trig_cnt, NPIX);
        check("R6 first trigger clock", first_trig, 19);
        check("R7 idle after eos", pix_valid, 0);
        check("R9 no error on clean scan", err, 0);

        // R9 reset rise during readout
        sys_reset();
        clear_counts();
        tick(1'b1);
        repeat (10) tick(1'b1);
        clock_no = 0;
        for (int c = 1; c <= 40; c++) tick(1'b0);
        check("R9 err before rise", err, 0);
        tick(1'b1);
        check("R9 err after rise in readout", err, 1);
        for (int c = 42; c <= LAST; c++) tick(1'b1);
        check("R9 scan completes trig count", trig_cnt, NPIX);
        check("R9 eos still produced", (eos_cycles > 0) ? 1 : 0, 1);
        check("R9 err sticky", err, 1);

        // R8 slave waits for start input
        sys_reset();
        clear_counts();
        slave_mode = 1'b1;
        tick(1'b1);
        repeat (10) tick(1'b1);
        clock_no = 0;
        for (int c = 1; c <= 30; c++) tick(1'b0);
        check("R8 slave idle without start", pix_valid, 0);
        check("R8 slave no trigger", trig_cnt, 0);
        ext_start_n = 1'b0;
        tick(1'b0);
        ext_start_n = 1'b1;
        check("R8 slave first slot valid", pix_valid, 1);
        check("R8 slave first index", pix_idx, 0);
        repeat (3) tick(1'b0);
        check("R8 slave slot length", pix_idx, 0);
        tick(1'b0);
        check("R8 slave second index", pix_idx, 1);
        for (int c = 0; c < 4 * NPIX + 4; c++) tick(1'b0);
        check("R8 slave trigger count", trig_cnt, NPIX);
        check("R10 idle index", pix_idx, 0);
        check("R7 slave eos length", eos_cycles > 0 ? 1 : 0, 1);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule